// File: doc/BRIEF.md
# VLAN Membership Table Engine

This block keeps a small table of VLAN records for an Ethernet switch. Each record holds a 13-bit VLAN ID, an 8-bit forwarding database number and a 2-bit member tag and 2-bit port state for each of up to eleven ports. A host reaches the engine through a plain 16-bit register bus. It sets up the VID register and three data registers, then writes the operation register with its top bit set. That write starts one of four commands: flush everything, load or purge one record, find the next record, or fetch and clear a pending violation. The host then polls the busy bit until it drops.

The table is searched one slot per clock. A get-next command walks the whole table and returns the valid record with the smallest VID above the VID register's contents. It writes that record back into the VID, data and operation registers, so issuing the same command again steps through the table in VID order. The switching path reports membership and miss violations on a side input. The engine keeps the first one it sees and holds a level interrupt until software collects it with the fetch-and-clear command.

Top module: `vlan_table_engine`

## Requirements
- R1: While reset is asserted, and after it, every register reads zero, the interrupt is low and the table holds no valid record.
- R2: A write to the operation register (address 0) with bit 15 set starts the command in bits 14:12 (1 flush, 2 load/purge, 3 get-next, 4 fetch-and-clear violation). Bit 15 reads back as busy for at least one and at most 16 cycles. Register writes made while busy is set are ignored.
- R3: The VID register (address 1) holds VID[12:0] in bits 12:0, where bit 12 is the page bit, and the valid flag in bit 13. Bits 15:14 read zero.
- R4: Data registers at addresses 2, 3 and 4 hold ports 0-3, 4-7 and 8-10. For port p the member tag sits at bit 4*(p mod 4) of register p/4, and the state sits two bits higher. Field bits of ports that do not exist read zero.
- R5: The database number is split across the operation register: bits 3:0 hold the low nibble and bits 11:8 the high nibble. It is taken on load and written back on a successful get-next.
- R6: Load with the valid flag set adds a record, or overwrites the record with the same VID. Load with the valid flag clear removes the matching record. If no record matches, the table stays as it was.
- R7: Loading a new VID into a full table sets the full flag (operation bit 7) and leaves the table unchanged. Overwriting an existing record in a full table does not set the flag.
- R8: Flush removes every record.
- R9: Get-next finds the valid record with the lowest VID strictly above the VID register's contents. It loads that record's VID with valid set, its data registers and its database number, so repeated commands walk the table in ascending order.
- R10: When no higher record exists, get-next sets the VID register to 0x0FFF with valid clear and leaves the data registers untouched.
- R11: The first violation reported on the side input is held, and any later one is dropped until it is cleared. The interrupt stays high while a violation is held.
- R12: Fetch-and-clear puts the held source port in operation bits 3:0 and the offending VID in the VID register. It sets operation bit 6 for a membership violation or bit 5 for a miss violation, then releases the held violation. With nothing held, both flags and bits 3:0 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data (combinational from address) |
| viol_valid_i | input | 1 | Violation report strobe from the switching path |
| viol_spid_i | input | 4 | Source port of the reported violation |
| viol_vid_i | input | 13 | VID of the reported violation |
| viol_member_i | input | 1 | 1 = membership violation, 0 = miss violation |
| irq_o | output | 1 | Level interrupt, high while a violation is held |

## Verification
A stale best-candidate or hit index in the search logic shows up in the VID register when the sixteen-cycle scan ends: get-next returns the wrong VID or skips one, and a load lands on a second copy that a later walk reveals. A valid flag stuck on or off in one slot appears only when a walk passes that VID or a fill reaches that slot, so the bench fills all sixteen slots and walks across purged and overwritten records. Faults in the violation latch appear at the interrupt pin one cycle after the report and in the operation register right after fetch-and-clear.

// File: rtl/vte_pkg.sv
package vte_pkg;

  localparam int VID_W   = 13;
  localparam int DB_W    = 8;
  localparam int DREG_W  = 16;
  localparam int NDREG   = 3;
  localparam int DATA_W  = DREG_W * NDREG;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_FLUSH = 3'd1,
    OP_LOAD  = 3'd2,
    OP_NEXT  = 3'd3,
    OP_VIOL  = 3'd4
  } vte_op_e;

  typedef struct packed {
    logic [VID_W-1:0]  vid;
    logic [DB_W-1:0]   db;
    logic [DATA_W-1:0] data;
  } vte_entry_t;

endpackage

// File: rtl/vte_table.sv
module vte_table
  import vte_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             wr_valid_i,
  input  vte_entry_t       wr_entry_i,
  input  logic [IDX_W-1:0] rd_a_idx_i,
  output logic             rd_a_valid_o,
  output logic [VID_W-1:0] rd_a_vid_o,
  input  logic [IDX_W-1:0] rd_b_idx_i,
  output vte_entry_t       rd_b_entry_o
);

  logic [ENTRIES-1:0] valid_vec;
  vte_entry_t         ent_arr [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    logic       v_q, v_n;
    vte_entry_t e_q, e_n;
    logic       hit_w;

    assign hit_w = wr_en_i && (wr_idx_i == IDX_W'(g));

    always_comb begin
      v_n = v_q;
      e_n = e_q;
      if (flush_i) begin
        v_n = 1'b0;
      end else if (hit_w) begin
        v_n = wr_valid_i;
        e_n = wr_entry_i;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) v_q <= 1'b0;
      else         v_q <= v_n;
    end

    always_ff @(posedge clk_i) begin
      if (hit_w) e_q <= e_n;
    end

    assign valid_vec[g] = v_q;
    assign ent_arr[g]   = e_q;
  end

  assign rd_a_valid_o = valid_vec[rd_a_idx_i];
  assign rd_a_vid_o   = ent_arr[rd_a_idx_i].vid;
  assign rd_b_entry_o = ent_arr[rd_b_idx_i];

endmodule

// File: rtl/vte_search.sv
module vte_search
  import vte_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             step_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             ent_valid_i,
  input  logic [VID_W-1:0] ent_vid_i,
  input  logic [VID_W-1:0] key_vid_i,
  output logic             hit_found_o,
  output logic [IDX_W-1:0] hit_idx_o,
  output logic             free_found_o,
  output logic [IDX_W-1:0] free_idx_o,
  output logic             best_found_o,
  output logic [IDX_W-1:0] best_idx_o
);

  logic             hit_f_q, free_f_q, best_f_q;
  logic [IDX_W-1:0] hit_i_q, free_i_q, best_i_q;
  logic [VID_W-1:0] best_v_q, best_v_n;
  logic             cur_hit, cur_free, cur_better;

  always_comb begin
    cur_hit    = ent_valid_i && (ent_vid_i == key_vid_i);
    cur_free   = !ent_valid_i;
    cur_better = ent_valid_i && (ent_vid_i > key_vid_i) &&
                 (!best_f_q || (ent_vid_i < best_v_q));

    hit_found_o  = hit_f_q || cur_hit;
    hit_idx_o    = (!hit_f_q && cur_hit) ? idx_i : hit_i_q;
    free_found_o = free_f_q || cur_free;
    free_idx_o   = (!free_f_q && cur_free) ? idx_i : free_i_q;
    best_found_o = best_f_q || cur_better;
    best_idx_o   = cur_better ? idx_i : best_i_q;
    best_v_n     = cur_better ? ent_vid_i : best_v_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_f_q  <= 1'b0;
      free_f_q <= 1'b0;
      best_f_q <= 1'b0;
      hit_i_q  <= '0;
      free_i_q <= '0;
      best_i_q <= '0;
      best_v_q <= '0;
    end else if (start_i) begin
      hit_f_q  <= 1'b0;
      free_f_q <= 1'b0;
      best_f_q <= 1'b0;
    end else if (step_i) begin
      hit_f_q  <= hit_found_o;
      hit_i_q  <= hit_idx_o;
      free_f_q <= free_found_o;
      free_i_q <= free_idx_o;
      best_f_q <= best_found_o;
      best_i_q <= best_idx_o;
      best_v_q <= best_v_n;
    end
  end

endmodule

// File: rtl/vte_viol.sv
module vte_viol
  import vte_pkg::*;
#(
  parameter int SPID_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [SPID_W-1:0] in_spid_i,
  input  logic [VID_W-1:0]  in_vid_i,
  input  logic              in_member_i,
  input  logic              clr_i,
  output logic              pend_o,
  output logic [SPID_W-1:0] spid_o,
  output logic [VID_W-1:0]  vid_o,
  output logic              member_o
);

  logic pend_n, capture;

  always_comb begin
    capture = in_valid_i && (!pend_o || clr_i);
    pend_n  = capture || (pend_o && !clr_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_o   <= 1'b0;
      spid_o   <= '0;
      vid_o    <= '0;
      member_o <= 1'b0;
    end else begin
      pend_o <= pend_n;
      if (capture) begin
        spid_o   <= in_spid_i;
        vid_o    <= in_vid_i;
        member_o <= in_member_i;
      end
    end
  end

endmodule

// File: rtl/vlan_table_engine.sv
module vlan_table_engine
  import vte_pkg::*;
#(
  parameter int ENTRIES   = 16,
  parameter int NUM_PORTS = 11,
  localparam int IDX_W    = $clog2(ENTRIES)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [2:0]  reg_addr_i,
  input  logic [15:0] reg_wdata_i,
  output logic [15:0] reg_rdata_o,
  input  logic        viol_valid_i,
  input  logic [3:0]  viol_spid_i,
  input  logic [12:0] viol_vid_i,
  input  logic        viol_member_i,
  output logic        irq_o
);

  localparam logic [2:0] A_OP  = 3'd0;
  localparam logic [2:0] A_VID = 3'd1;
  localparam logic [2:0] A_D0  = 3'd2;
  localparam logic [VID_W-1:0] END_VID = 13'h0FFF;

  function automatic logic [DREG_W-1:0] port_mask(int k);
    logic [DREG_W-1:0] m;
    m = '0;
    for (int p = 0; p < 4; p++) begin
      if (4*k + p < NUM_PORTS) m[4*p +: 4] = 4'hF;
    end
    return m;
  endfunction

  // reset synchronizer: asserts at once, releases on the clock
  logic rst_s1_q, rst_n_s;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_s1_q <= 1'b0;
      rst_n_s  <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_n_s  <= rst_s1_q;
    end
  end

  logic              busy_q, busy_n;
  vte_op_e           opc_q, opc_n;
  logic [3:0]        dbhi_q, dbhi_n, lo_q, lo_n;
  logic              full_q, full_n, mf_q, mf_n, xf_q, xf_n;
  logic [VID_W-1:0]  vid_q, vid_n;
  logic              vval_q, vval_n;
  logic [DREG_W-1:0] dreg_q [NDREG];
  logic [DREG_W-1:0] dreg_n [NDREG];
  logic [IDX_W-1:0]  idx_q, idx_n;

  logic             tbl_flush, tbl_we, tbl_wval;
  logic [IDX_W-1:0] tbl_widx;
  vte_entry_t       tbl_went, rd_b_ent;
  logic             rd_a_valid;
  logic [VID_W-1:0] rd_a_vid;
  logic             srch_start;
  logic             hit_f, free_f, best_f;
  logic [IDX_W-1:0] hit_i, free_i, best_i;
  logic             v_pend, v_member, v_clr;
  logic [3:0]       v_spid;
  logic [VID_W-1:0] v_vid;
  logic             last_slot;

  assign tbl_went = '{vid: vid_q, db: {dbhi_q, lo_q},
                      data: {dreg_q[2], dreg_q[1], dreg_q[0]}};

  vte_table #(.ENTRIES(ENTRIES)) u_table (
    .clk_i        (clk_i),
    .rst_ni       (rst_n_s),
    .flush_i      (tbl_flush),
    .wr_en_i      (tbl_we),
    .wr_idx_i     (tbl_widx),
    .wr_valid_i   (tbl_wval),
    .wr_entry_i   (tbl_went),
    .rd_a_idx_i   (idx_q),
    .rd_a_valid_o (rd_a_valid),
    .rd_a_vid_o   (rd_a_vid),
    .rd_b_idx_i   (best_i),
    .rd_b_entry_o (rd_b_ent)
  );

  vte_search #(.ENTRIES(ENTRIES)) u_search (
    .clk_i        (clk_i),
    .rst_ni       (rst_n_s),
    .start_i      (srch_start),
    .step_i       (busy_q),
    .idx_i        (idx_q),
    .ent_valid_i  (rd_a_valid),
    .ent_vid_i    (rd_a_vid),
    .key_vid_i    (vid_q),
    .hit_found_o  (hit_f),
    .hit_idx_o    (hit_i),
    .free_found_o (free_f),
    .free_idx_o   (free_i),
    .best_found_o (best_f),
    .best_idx_o   (best_i)
  );

  vte_viol #(.SPID_W(4)) u_viol (
    .clk_i       (clk_i),
    .rst_ni      (rst_n_s),
    .in_valid_i  (viol_valid_i),
    .in_spid_i   (viol_spid_i),
    .in_vid_i    (viol_vid_i),
    .in_member_i (viol_member_i),
    .clr_i       (v_clr),
    .pend_o      (v_pend),
    .spid_o      (v_spid),
    .vid_o       (v_vid),
    .member_o    (v_member)
  );

  assign irq_o     = v_pend;
  assign last_slot = (idx_q == IDX_W'(ENTRIES-1));

  // next-state logic
  always_comb begin
    busy_n = busy_q;  opc_n = opc_q;  dbhi_n = dbhi_q;  lo_n = lo_q;
    full_n = full_q;  mf_n = mf_q;    xf_n = xf_q;
    vid_n  = vid_q;   vval_n = vval_q; idx_n = idx_q;
    for (int k = 0; k < NDREG; k++) dreg_n[k] = dreg_q[k];
    tbl_flush = 1'b0; tbl_we = 1'b0; tbl_wval = 1'b0; tbl_widx = '0;
    v_clr = 1'b0; srch_start = 1'b0;

    if (!busy_q && reg_we_i) begin
      if (reg_addr_i == A_OP) begin
        opc_n  = vte_op_e'(reg_wdata_i[14:12]);
        dbhi_n = reg_wdata_i[11:8];
        lo_n   = reg_wdata_i[3:0];
        if (reg_wdata_i[15]) begin
          busy_n = 1'b1; idx_n = '0; srch_start = 1'b1;
          full_n = 1'b0; mf_n = 1'b0; xf_n = 1'b0;
        end
      end else if (reg_addr_i == A_VID) begin
        vid_n  = reg_wdata_i[VID_W-1:0];
        vval_n = reg_wdata_i[13];
      end else begin
        for (int k = 0; k < NDREG; k++) begin
          if (reg_addr_i == 3'(A_D0 + k)) dreg_n[k] = reg_wdata_i & port_mask(k);
        end
      end
    end

    if (busy_q) begin
      unique case (opc_q)
        OP_FLUSH: begin
          tbl_flush = 1'b1;
          busy_n    = 1'b0;
        end
        OP_VIOL: begin
          v_clr  = v_pend;
          mf_n   = v_pend && v_member;
          xf_n   = v_pend && !v_member;
          lo_n   = v_pend ? v_spid : 4'h0;
          if (v_pend) begin
            vid_n  = v_vid;
            vval_n = 1'b0;
          end
          busy_n = 1'b0;
        end
        OP_LOAD: begin
          idx_n = idx_q + 1'b1;
          if (last_slot) begin
            busy_n = 1'b0;
            if (hit_f) begin
              tbl_we = 1'b1; tbl_widx = hit_i; tbl_wval = vval_q;
            end else if (vval_q) begin
              if (free_f) begin
                tbl_we = 1'b1; tbl_widx = free_i; tbl_wval = 1'b1;
              end else begin
                full_n = 1'b1;
              end
            end
          end
        end
        OP_NEXT: begin
          idx_n = idx_q + 1'b1;
          if (last_slot) begin
            busy_n = 1'b0;
            if (best_f) begin
              vid_n  = rd_b_ent.vid;
              vval_n = 1'b1;
              dbhi_n = rd_b_ent.db[7:4];
              lo_n   = rd_b_ent.db[3:0];
              for (int k = 0; k < NDREG; k++)
                dreg_n[k] = rd_b_ent.data[DREG_W*k +: DREG_W];
            end else begin
              vid_n  = END_VID;
              vval_n = 1'b0;
            end
          end
        end
        default: busy_n = 1'b0;
      endcase
    end
  end

  // state registers
  always_ff @(posedge clk_i or negedge rst_n_s) begin
    if (!rst_n_s) begin
      busy_q <= 1'b0; opc_q <= OP_NONE; dbhi_q <= '0; lo_q <= '0;
      full_q <= 1'b0; mf_q <= 1'b0; xf_q <= 1'b0;
      vid_q  <= '0;   vval_q <= 1'b0; idx_q <= '0;
      for (int k = 0; k < NDREG; k++) dreg_q[k] <= '0;
    end else begin
      busy_q <= busy_n; opc_q <= opc_n; dbhi_q <= dbhi_n; lo_q <= lo_n;
      full_q <= full_n; mf_q <= mf_n; xf_q <= xf_n;
      vid_q  <= vid_n;  vval_q <= vval_n; idx_q <= idx_n;
      for (int k = 0; k < NDREG; k++) dreg_q[k] <= dreg_n[k];
    end
  end

  // register read
  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == A_OP) begin
      reg_rdata_o = {busy_q, opc_q, dbhi_q, full_q, mf_q, xf_q, 1'b0, lo_q};
    end else if (reg_addr_i == A_VID) begin
      reg_rdata_o = {2'b00, vval_q, vid_q};
    end else begin
      for (int k = 0; k < NDREG; k++) begin
        if (reg_addr_i == 3'(A_D0 + k)) reg_rdata_o = dreg_q[k];
      end
    end
  end

endmodule

// File: rtl/vte_checker.sv
module vte_checker #(
  parameter int ENTRIES = 16,
  localparam int CNT_W  = $clog2(ENTRIES + 1) + 1
) (
  input logic clk_i,
  input logic rst_ni,
  input logic busy_i,
  input logic op_start_i,
  input logic viol_valid_i,
  input logic irq_i
);

  logic [CNT_W-1:0] busy_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_cnt <= '0;
    else if (busy_i) busy_cnt <= busy_cnt + 1'b1;
    else             busy_cnt <= '0;
  end

  // R2
  busy_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_cnt <= CNT_W'(ENTRIES));

  // R2
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> $past(op_start_i));

  // R11
  irq_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_valid_i && !irq_i |=> irq_i);

  // R11
  irq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i && !busy_i |=> irq_i);

  // R11
  irq_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_i && !viol_valid_i |=> !irq_i);

endmodule

bind vlan_table_engine vte_checker #(.ENTRIES(ENTRIES)) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_n_s),
  .busy_i       (busy_q),
  .op_start_i   (reg_we_i && (reg_addr_i == 3'd0) && reg_wdata_i[15]),
  .viol_valid_i (viol_valid_i),
  .irq_i        (irq_o)
);

// File: tb/vlan_table_engine_tb_top.sv
module vlan_table_engine_tb_top;

  localparam int NV = 62;
  // vector: kind[24:23] (0 write, 1 command, 2 read-compare), addr[22:20], data[19:4], req[3:0]
  localparam logic [24:0] VEC [NV] = '{
    {2'd1, 3'd0, 16'h9000, 4'd8},   // R8 flush
    {2'd0, 3'd1, 16'h2005, 4'd6},   // R6 load VID 5
    {2'd0, 3'd2, 16'h1234, 4'd4},
    {2'd0, 3'd3, 16'h5678, 4'd4},
    {2'd0, 3'd4, 16'hFABC, 4'd4},
    {2'd2, 3'd4, 16'h0ABC, 4'd4},   // R4 absent port bits
    {2'd1, 3'd0, 16'hAA05, 4'd6},
    {2'd0, 3'd1, 16'h3003, 4'd3},   // R3 page bit
    {2'd0, 3'd2, 16'h1111, 4'd4},
    {2'd0, 3'd3, 16'h2222, 4'd4},
    {2'd0, 3'd4, 16'h0333, 4'd4},
    {2'd1, 3'd0, 16'hA30C, 4'd6},
    {2'd0, 3'd1, 16'h2100, 4'd6},
    {2'd0, 3'd2, 16'h0000, 4'd4},
    {2'd0, 3'd3, 16'h0000, 4'd4},
    {2'd0, 3'd4, 16'h0000, 4'd4},
    {2'd1, 3'd0, 16'hA000, 4'd6},
    {2'd0, 3'd1, 16'h0000, 4'd9},   // R9 walk
    {2'd1, 3'd0, 16'hB000, 4'd9},
    {2'd2, 3'd1, 16'h2005, 4'd9},
    {2'd2, 3'd0, 16'h3A05, 4'd5},   // R5 db nibbles
    {2'd2, 3'd2, 16'h1234, 4'd4},
    {2'd2, 3'd3, 16'h5678, 4'd4},
    {2'd2, 3'd4, 16'h0ABC, 4'd4},
    {2'd1, 3'd0, 16'hB000, 4'd9},
    {2'd2, 3'd1, 16'h2100, 4'd9},
    {2'd2, 3'd0, 16'h3000, 4'd5},
    {2'd2, 3'd2, 16'h0000, 4'd9},
    {2'd1, 3'd0, 16'hB000, 4'd9},
    {2'd2, 3'd1, 16'h3003, 4'd3},
    {2'd2, 3'd0, 16'h330C, 4'd5},
    {2'd2, 3'd2, 16'h1111, 4'd9},
    {2'd1, 3'd0, 16'hB000, 4'd10},  // R10 end of walk
    {2'd2, 3'd1, 16'h0FFF, 4'd10},
    {2'd2, 3'd2, 16'h1111, 4'd10},
    {2'd0, 3'd1, 16'h0100, 4'd6},   // R6 purge 0x100
    {2'd1, 3'd0, 16'hA000, 4'd6},
    {2'd0, 3'd1, 16'h0000, 4'd6},
    {2'd1, 3'd0, 16'hB000, 4'd6},
    {2'd2, 3'd1, 16'h2005, 4'd6},
    {2'd1, 3'd0, 16'hB000, 4'd6},
    {2'd2, 3'd1, 16'h3003, 4'd6},
    {2'd0, 3'd1, 16'h2005, 4'd6},   // R6 overwrite VID 5
    {2'd0, 3'd2, 16'h00FF, 4'd6},
    {2'd0, 3'd3, 16'h0000, 4'd6},
    {2'd0, 3'd4, 16'h0000, 4'd6},
    {2'd1, 3'd0, 16'hA101, 4'd6},
    {2'd0, 3'd1, 16'h0004, 4'd6},
    {2'd1, 3'd0, 16'hB000, 4'd6},
    {2'd2, 3'd1, 16'h2005, 4'd6},
    {2'd2, 3'd0, 16'h3101, 4'd5},
    {2'd2, 3'd2, 16'h00FF, 4'd6},
    {2'd0, 3'd1, 16'h0777, 4'd6},   // R6 purge of absent VID
    {2'd1, 3'd0, 16'hA000, 4'd6},
    {2'd0, 3'd1, 16'h0000, 4'd6},
    {2'd1, 3'd0, 16'hB000, 4'd6},
    {2'd2, 3'd1, 16'h2005, 4'd6},
    {2'd1, 3'd0, 16'h9000, 4'd8},   // R8 flush empties table
    {2'd0, 3'd1, 16'h0000, 4'd8},
    {2'd1, 3'd0, 16'hB000, 4'd8},
    {2'd2, 3'd1, 16'h0FFF, 4'd8},
    {2'd2, 3'd2, 16'h00FF, 4'd10}
  };

  logic        clk, rst_n, we, vv, vmem, irq;
  logic [2:0]  addr;
  logic [15:0] wdata, rdata;
  logic [3:0]  vspid;
  logic [12:0] vvid;
  int          n_chk, n_bad;
  bit          done;

  vlan_table_engine dut_i (
    .clk_i (clk), .rst_ni (rst_n), .reg_we_i (we), .reg_addr_i (addr),
    .reg_wdata_i (wdata), .reg_rdata_o (rdata), .viol_valid_i (vv),
    .viol_spid_i (vspid), .viol_vid_i (vvid), .viol_member_i (vmem),
    .irq_o (irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input int rq);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [15:0] exp, input int rq);
    @(negedge clk);
    addr = a;
    #1 check(rdata, exp, rq);
  endtask

  task automatic wait_idle(input int rq);
    int n = 0;
    addr = 3'd0;
    #1;
    while (rdata[15] && n < 40) begin
      n++;
      @(negedge clk);
      #1;
    end
    check(16'((n >= 1) && (n <= 16)), 16'd1, rq);  // R2 busy window
  endtask

  task automatic cmd(input logic [15:0] op, input int rq);
    wr(3'd0, op);
    wait_idle(rq);
  endtask

  task automatic viol(input logic [3:0] sp, input logic [12:0] vd, input logic m);
    @(negedge clk);
    vv = 1'b1; vspid = sp; vvid = vd; vmem = m;
    @(negedge clk);
    vv = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #1500000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    n_chk = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    vv = 1'b0; vspid = '0; vvid = '0; vmem = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 5; a++) rd(3'(a), 16'h0000, 1);
    check(16'(irq), 16'h0, 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [1:0]  k;
      logic [2:0]  a;
      logic [15:0] d;
      int          rq;
      k = VEC[i][24:23]; a = VEC[i][22:20]; d = VEC[i][19:4]; rq = int'(VEC[i][3:0]);
      if (k == 2'd0)      wr(a, d);
      else if (k == 2'd1) cmd(d, rq);
      else                rd(a, d, rq);
    end

    // R7 fill all sixteen slots, then one more
    cmd(16'h9000, 8);
    for (int i = 0; i < 16; i++) begin
      wr(3'd1, 16'h2010 + 16'(i));
      cmd(16'hA000, 6);
    end
    wr(3'd1, 16'h2500);
    cmd(16'hA000, 7);
    rd(3'd0, 16'h2080, 7);
    wr(3'd1, 16'h04FF);
    cmd(16'hB000, 7);
    rd(3'd1, 16'h0FFF, 7);
    wr(3'd1, 16'h001E);
    cmd(16'hB000, 6);
    rd(3'd1, 16'h201F, 6);
    wr(3'd1, 16'h2010);
    cmd(16'hA000, 7);
    rd(3'd0, 16'h2000, 7);

    // R2 writes during busy are ignored
    wr(3'd2, 16'h0000);
    wr(3'd1, 16'h2010);
    wr(3'd0, 16'hA000);
    wr(3'd2, 16'hBEEF);
    wr(3'd1, 16'h1FFF);
    wait_idle(2);
    rd(3'd2, 16'h0000, 2);
    rd(3'd1, 16'h2010, 2);

    // R11 / R12 violations
    rd(3'd0, 16'h2000, 11);
    check(16'(irq), 16'h0, 11);
    viol(4'd7, 13'h0123, 1'b1);
    check(16'(irq), 16'h1, 11);
    viol(4'd2, 13'h1ABC, 1'b0);
    check(16'(irq), 16'h1, 11);
    cmd(16'hC000, 12);
    rd(3'd0, 16'h4047, 12);
    rd(3'd1, 16'h0123, 12);
    check(16'(irq), 16'h0, 11);
    viol(4'd2, 13'h1ABC, 1'b0);
    cmd(16'hC000, 12);
    rd(3'd0, 16'h4022, 12);
    rd(3'd1, 16'h1ABC, 12);
    cmd(16'hC000, 12);
    rd(3'd0, 16'h4000, 12);

    // R1 reset in the middle of activity
    viol(4'd3, 13'h0042, 1'b1);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(16'(irq), 16'h0, 1);
    for (int a = 0; a < 5; a++) rd(3'(a), 16'h0000, 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    wr(3'd1, 16'h0000);
    cmd(16'hB000, 1);
    rd(3'd1, 16'h0FFF, 1);

    finish_run();
  end

endmodule